// File: doc/BRIEF.md
# Paired register file with in-place stepping

This block holds six 16-bit register pairs for a small byte-oriented processor datapath: three general pairs (BC, DE, HL), a scratch pair WZ that the sequencer uses for address and operand staging, the program counter and the stack pointer. A 5-bit select code names either a whole pair or a single byte of a pair. One select drives the read side and a second select drives the write side. Both sides can act in the same clock cycle, so a value can be moved from one pair to another over the shared 16-bit bus in a single step.

The write side can also adjust the selected pair in place. A 2-bit step field adds one, subtracts one or adds two. It does not use the bus or the write enable. The sequencer uses this to advance the program counter and to move the stack pointer. The read side is purely combinational and the write side acts on the rising clock edge. A reader therefore always sees the value held before the edge.

Top module: `pair_regfile`

## Requirements
- R1: An active-low asynchronous reset clears all six pairs to 0000h, so every select code reads back zero once reset is released.
- R2: A read select with bit 4 set drives the whole 16-bit pair named by bits 3:1 onto `bus_out`. Bit 0 is ignored. Index 0 is BC, 1 is DE, 2 is HL, 3 is WZ, 4 is PC and 5 is SP, which gives the codes 10000, 10010, 10100, 10110, 11000 and 11010.
- R3: A read select with bit 4 clear picks one byte of the pair indexed by bits 3:1. Bit 0 clear picks the high byte and bit 0 set picks the low byte. The byte is zero-extended, so 00100 reads H and 00101 reads L.
- R4: When `out_en` is low, `bus_out` is 0000h whatever the read select is.
- R5: With `wr_en` high and bit 4 of `wr_sel` set, the pair indexed by `wr_sel[3:1]` takes all 16 bits of `bus_in` at the clock edge.
- R6: With `wr_en` high and bit 4 of `wr_sel` clear, `bus_in[7:0]` is written into the byte chosen as in R3. The other byte of that pair keeps its value.
- R7: With `wr_en` low, step code 01 adds 1, 10 subtracts 1 and 11 adds 2 to the pair indexed by `wr_sel[3:1]`, whatever the state of bit 4. The arithmetic wraps modulo 2^16 and `bus_in` is ignored.
- R8: When `wr_en` is high and the step code is non-zero in the same cycle, the bus write is applied and the step is dropped.
- R9: In one cycle, the read side returns the value held before the edge while the write side updates a pair. This allows a one-cycle pair-to-pair transfer such as WZ to PC, and it also holds when both sides select the same pair.
- R10: A write or step changes only the pair it selects. Pair indices 6 and 7 (codes 01100–01111, 11100–11111) hold no storage: writes and steps to them are ignored and reads return zero.
- R11: Step code 00 with `wr_en` low leaves every pair unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel | input | 5 | Read select code (pair or byte) |
| out_en | input | 1 | Enables the read value onto `bus_out` |
| wr_sel | input | 5 | Write and step select code |
| wr_en | input | 1 | Loads `bus_in` into the write-selected pair or byte |
| step_sel | input | 2 | In-place adjust: 00 none, 01 +1, 10 −1, 11 +2 |
| bus_in | input | 16 | Data to be written |
| bus_out | output | 16 | Read data, zero-extended for byte reads |

## Verification
A bus write and an in-place step can be requested together on the same pair, because both are aimed by `wr_sel`. The bench drives `wr_en` together with each non-zero step code on every pair. In each case the stepped result differs from the bus value, so a step that wins over the write, or adds to it, shows up when the pair is read back. The sweep also reads a pair on the same edge that another pair, or the same pair, is written. The bus must then show the value from before the edge, and the written pair must hold the transferred value one cycle later.

// File: rtl/pair_regfile_pkg.sv
package pair_regfile_pkg;

  // Select code layout: [4] whole pair, [3:1] pair index, [0] low byte.
  localparam int SEL_W = 5;
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10,
    STEP_UP2  = 2'b11
  } step_e;

  function automatic logic [IDX_W-1:0] sel_index(input logic [SEL_W-1:0] s);
    return s[3:1];
  endfunction

  function automatic logic sel_is_pair(input logic [SEL_W-1:0] s);
    return s[4];
  endfunction

  function automatic logic sel_is_low(input logic [SEL_W-1:0] s);
    return s[0];
  endfunction

  // Signed adjustment applied by a step code.
  function automatic int step_amount(input step_e op);
    case (op)
      STEP_UP:   return 1;
      STEP_DOWN: return -1;
      STEP_UP2:  return 2;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/pair_regfile_dec.sv
module pair_regfile_dec
  import pair_regfile_pkg::*;
#(
  parameter int NUM_PAIRS = 6   // at most 2**IDX_W
) (
  input  logic [SEL_W-1:0]     sel,
  output logic [NUM_PAIRS-1:0] hit,
  output logic                 is_pair,
  output logic                 is_low
);

  logic [IDX_W-1:0] idx;

  assign idx     = sel_index(sel);
  assign is_pair = sel_is_pair(sel);
  assign is_low  = sel_is_low(sel);

  // Indices with no storage behind them hit nothing.
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_hit
    assign hit[g] = (idx == IDX_W'(g));
  end

endmodule

// File: rtl/pair_regfile_pair.sv
module pair_regfile_pair
  import pair_regfile_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_whole,
  input  logic              wr_high,
  input  logic              wr_low,
  input  step_e             step_op,
  input  logic [2*BYTE_W-1:0] din,
  output logic [2*BYTE_W-1:0] q
);

  localparam int PAIR_W = 2 * BYTE_W;

  logic [PAIR_W-1:0] stepped;
  logic              step_go;

  assign stepped = q + PAIR_W'(step_amount(step_op));
  assign step_go = (step_op != STEP_NONE);

  // Bus loads outrank the in-place step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_whole) begin
      q <= din;
    end else if (wr_high) begin
      q[PAIR_W-1:BYTE_W] <= din[BYTE_W-1:0];
    end else if (wr_low) begin
      q[BYTE_W-1:0] <= din[BYTE_W-1:0];
    end else if (step_go) begin
      q <= stepped;
    end
  end

endmodule

// File: rtl/pair_regfile_rdmux.sv
module pair_regfile_rdmux #(
  parameter int NUM_PAIRS = 6,
  parameter int BYTE_W    = 8
) (
  input  logic [NUM_PAIRS*2*BYTE_W-1:0] pairs_flat,
  input  logic [NUM_PAIRS-1:0]          hit,
  input  logic                          is_pair,
  input  logic                          is_low,
  input  logic                          oe,
  output logic [2*BYTE_W-1:0]           dout
);

  localparam int PAIR_W = 2 * BYTE_W;

  logic [PAIR_W-1:0] picked;
  logic [BYTE_W-1:0] byte_pick;

  // AND-OR selection; the hit vector is one-hot or empty.
  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (hit[i]) picked = picked | pairs_flat[i*PAIR_W +: PAIR_W];
    end
  end

  assign byte_pick = is_low ? picked[BYTE_W-1:0] : picked[PAIR_W-1:BYTE_W];

  always_comb begin
    if (!oe)          dout = '0;
    else if (is_pair) dout = picked;
    else              dout = {{BYTE_W{1'b0}}, byte_pick};
  end

endmodule

// File: rtl/pair_regfile.sv
module pair_regfile
  import pair_regfile_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int BYTE_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [4:0]          rd_sel,
  input  logic                out_en,
  input  logic [4:0]          wr_sel,
  input  logic                wr_en,
  input  logic [1:0]          step_sel,
  input  logic [2*BYTE_W-1:0] bus_in,
  output logic [2*BYTE_W-1:0] bus_out
);

  localparam int PAIR_W = 2 * BYTE_W;
  localparam int FLAT_W = NUM_PAIRS * PAIR_W;

  // Decoded select events, kept as named wires for the checker.
  logic [NUM_PAIRS-1:0] rd_hit;
  logic [NUM_PAIRS-1:0] wr_dec_hit;
  logic [NUM_PAIRS-1:0] wr_hit;
  logic [NUM_PAIRS-1:0] step_hit;
  logic                 rd_is_pair, rd_is_low;
  logic                 wr_is_pair, wr_is_low;
  step_e                step_op;
  logic [FLAT_W-1:0]    pairs_flat;

  assign step_op = step_e'(step_sel);

  pair_regfile_dec #(.NUM_PAIRS(NUM_PAIRS)) u_rd_dec (
    .sel     (rd_sel),
    .hit     (rd_hit),
    .is_pair (rd_is_pair),
    .is_low  (rd_is_low)
  );

  pair_regfile_dec #(.NUM_PAIRS(NUM_PAIRS)) u_wr_dec (
    .sel     (wr_sel),
    .hit     (wr_dec_hit),
    .is_pair (wr_is_pair),
    .is_low  (wr_is_low)
  );

  assign wr_hit   = wr_en ? wr_dec_hit : '0;
  assign step_hit = (!wr_en && step_op != STEP_NONE) ? wr_dec_hit : '0;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    logic  ld_whole, ld_high, ld_low;
    step_e op_g;

    assign ld_whole = wr_hit[g] & wr_is_pair;
    assign ld_high  = wr_hit[g] & ~wr_is_pair & ~wr_is_low;
    assign ld_low   = wr_hit[g] & ~wr_is_pair & wr_is_low;
    assign op_g     = step_hit[g] ? step_op : STEP_NONE;

    pair_regfile_pair #(.BYTE_W(BYTE_W)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_whole (ld_whole),
      .wr_high  (ld_high),
      .wr_low   (ld_low),
      .step_op  (op_g),
      .din      (bus_in),
      .q        (pairs_flat[g*PAIR_W +: PAIR_W])
    );
  end

  pair_regfile_rdmux #(.NUM_PAIRS(NUM_PAIRS), .BYTE_W(BYTE_W)) u_rdmux (
    .pairs_flat (pairs_flat),
    .hit        (rd_hit),
    .is_pair    (rd_is_pair),
    .is_low     (rd_is_low),
    .oe         (out_en),
    .dout       (bus_out)
  );

endmodule

// File: rtl/pair_regfile_chk.sv
module pair_regfile_chk #(
  parameter int NUM_PAIRS = 6,
  parameter int BYTE_W    = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [4:0]                    wr_sel,
  input logic                          wr_en,
  input logic [1:0]                    step_sel,
  input logic                          out_en,
  input logic [2*BYTE_W-1:0]           bus_in,
  input logic [2*BYTE_W-1:0]           bus_out,
  input logic [NUM_PAIRS*2*BYTE_W-1:0] pairs_flat,
  input logic [NUM_PAIRS-1:0]          wr_hit,
  input logic [NUM_PAIRS-1:0]          step_hit
);

  localparam int PAIR_W = 2 * BYTE_W;

  logic [2:0]        w_idx;
  logic              w_ok;
  logic [PAIR_W-1:0] w_cur;
  logic [PAIR_W-1:0] w_expect_step;

  assign w_idx = wr_sel[3:1];
  assign w_ok  = int'(w_idx) < NUM_PAIRS;
  assign w_cur = pairs_flat[int'(w_idx)*PAIR_W +: PAIR_W];

  always_comb begin
    case (step_sel)
      2'b01:   w_expect_step = w_cur + PAIR_W'(1);
      2'b10:   w_expect_step = w_cur - PAIR_W'(1);
      2'b11:   w_expect_step = w_cur + PAIR_W'(2);
      default: w_expect_step = w_cur;
    endcase
  end

  assert_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> bus_out == '0);

  assert_whole_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel[4] && w_ok) |=>
      pairs_flat[int'($past(w_idx))*PAIR_W +: PAIR_W] == $past(bus_in));

  assert_step_math_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && step_sel != 2'b00 && w_ok) |=>
      pairs_flat[int'($past(w_idx))*PAIR_W +: PAIR_W] == $past(w_expect_step));

  assert_write_beats_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && step_sel != 2'b00 && wr_sel[4] && w_ok) |=>
      pairs_flat[int'($past(w_idx))*PAIR_W +: PAIR_W] == $past(bus_in));

  assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit | step_hit));

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_hold
    assert_pair_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit[g] && !step_hit[g]) |=> $stable(pairs_flat[g*PAIR_W +: PAIR_W]));
  end

endmodule

bind pair_regfile pair_regfile_chk #(.NUM_PAIRS(NUM_PAIRS), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_sel     (wr_sel),
  .wr_en      (wr_en),
  .step_sel   (step_sel),
  .out_en     (out_en),
  .bus_in     (bus_in),
  .bus_out    (bus_out),
  .pairs_flat (pairs_flat),
  .wr_hit     (wr_hit),
  .step_hit   (step_hit)
);

// File: tb/pair_regfile_tb_top.sv
module pair_regfile_tb_top;

  localparam int NP = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_sel, wr_sel;
  logic        out_en, wr_en;
  logic [1:0]  step_sel;
  logic [15:0] bus_in;
  logic [15:0] bus_out;

  always #2 clk = ~clk;

  pair_regfile dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_sel   (rd_sel),
    .out_en   (out_en),
    .wr_sel   (wr_sel),
    .wr_en    (wr_en),
    .step_sel (step_sel),
    .bus_in   (bus_in),
    .bus_out  (bus_out)
  );

  logic [15:0] mdl [NP];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] pcode(input int p);
    return {1'b1, 3'(p), 1'b0};
  endfunction

  function automatic logic [15:0] exp_read(input logic [4:0] s, input logic oe);
    int idx = int'(s[3:1]);
    if (!oe || idx >= NP) return 16'h0000;
    if (s[4]) return mdl[idx];
    return s[0] ? {8'h00, mdl[idx][7:0]} : {8'h00, mdl[idx][15:8]};
  endfunction

  function automatic logic [15:0] after_step(input logic [15:0] v, input logic [1:0] e);
    case (e)
      2'b01:   return v + 16'd1;
      2'b10:   return v + 16'hFFFF;
      2'b11:   return v + 16'd2;
      default: return v;
    endcase
  endfunction

  task automatic cycle(input logic [4:0] rs, input logic oe, input logic [4:0] ws,
                       input logic we, input logic [1:0] e, input logic [15:0] din,
                       input string req);
    int idx;
    @(negedge clk);
    rd_sel = rs; out_en = oe; wr_sel = ws; wr_en = we; step_sel = e; bus_in = din;
    #1;
    chk(req, $sformatf("read sel=%b oe=%b", rs, oe), bus_out, exp_read(rs, oe));
    @(posedge clk);
    idx = int'(ws[3:1]);
    if (idx < NP) begin
      if (we) begin
        if (ws[4])      mdl[idx] = din;
        else if (ws[0]) mdl[idx][7:0] = din[7:0];
        else            mdl[idx][15:8] = din[7:0];
      end else begin
        mdl[idx] = after_step(mdl[idx], e);
      end
    end
  endtask

  task automatic readback(input string req);
    for (int s = 0; s < 32; s++) cycle(5'(s), 1'b1, 5'b11110, 1'b0, 2'b00, 16'h0000, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int p = 0; p < NP; p++) mdl[p] = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rd_sel = '0; wr_sel = '0; out_en = 1'b0; wr_en = 1'b0;
    step_sel = '0; bus_in = '0;
    for (int p = 0; p < NP; p++) mdl[p] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: everything reads zero after reset.
    readback("R1");

    // R5: whole-pair loads with distinct values, then full sweep for R2, R3.
    for (int p = 0; p < NP; p++)
      cycle(5'b00000, 1'b0, pcode(p), 1'b1, 2'b00, 16'h1100 * 16'(p + 1) + 16'h0023 * 16'(p + 1), "R5");
    readback("R2");
    readback("R3");

    // R4: output disabled for every select.
    for (int s = 0; s < 32; s++) cycle(5'(s), 1'b0, 5'b11110, 1'b0, 2'b00, 16'h0000, "R4");

    // R6: byte loads into every byte, odd bus upper halves must not leak.
    for (int s = 0; s < 12; s++)
      cycle(5'b00000, 1'b0, 5'(s), 1'b1, 2'b00, 16'hEE00 | 16'(8'h40 + s), "R6");
    readback("R6");

    // R10: writes and steps to storage-less indices are dropped.
    for (int s = 12; s < 16; s++) cycle(5'b00000, 1'b0, 5'(s), 1'b1, 2'b00, 16'hDEAD, "R10");
    for (int s = 28; s < 32; s++) cycle(5'b00000, 1'b0, 5'(s), 1'b1, 2'b00, 16'hBEEF, "R10");
    cycle(5'b00000, 1'b0, 5'b11100, 1'b0, 2'b01, 16'h0000, "R10");
    readback("R10");

    // R11: null step on each pair.
    for (int p = 0; p < NP; p++) cycle(5'b00000, 1'b0, pcode(p), 1'b0, 2'b00, 16'h7777, "R11");
    readback("R11");

    // R7: every step code on every pair around the wrap points; bus carries junk.
    for (int p = 0; p < NP; p++) begin
      for (int v = 0; v < 6; v++) begin
        for (int e = 1; e < 4; e++) begin
          logic [15:0] seed;
          case (v)
            0: seed = 16'h0000;
            1: seed = 16'h0001;
            2: seed = 16'h7FFF;
            3: seed = 16'hFFFE;
            4: seed = 16'hFFFF;
            default: seed = 16'h12FF;
          endcase
          cycle(5'b00000, 1'b0, pcode(p), 1'b1, 2'b00, seed, "R7");
          cycle(5'b00000, 1'b0, (v == 5) ? {1'b0, 3'(p), 1'b1} : pcode(p), 1'b0, 2'(e), 16'h5A5A, "R7");
          cycle(pcode(p), 1'b1, 5'b11110, 1'b0, 2'b00, 16'h0000, "R7");
        end
      end
    end
    readback("R10");

    // R8: load and step together; load wins.
    for (int p = 0; p < NP; p++) begin
      for (int e = 1; e < 4; e++) begin
        cycle(5'b00000, 1'b0, pcode(p), 1'b1, 2'b00, 16'h3000, "R8");
        cycle(5'b00000, 1'b0, pcode(p), 1'b1, 2'(e), 16'hA0C0 + 16'(p), "R8");
        cycle(pcode(p), 1'b1, 5'b11110, 1'b0, 2'b00, 16'h0000, "R8");
      end
    end

    // R9: WZ to PC transfer in one cycle; read of a pair being written shows old value.
    cycle(5'b00000, 1'b0, pcode(3), 1'b1, 2'b00, 16'hBEEF, "R9");
    cycle(5'b00000, 1'b0, pcode(4), 1'b1, 2'b00, 16'h0100, "R9");
    cycle(pcode(3), 1'b1, pcode(4), 1'b1, 2'b00, 16'hBEEF, "R9");
    cycle(pcode(4), 1'b1, 5'b11110, 1'b0, 2'b00, 16'h0000, "R9");
    chk("R9", "PC after transfer", bus_out, 16'hBEEF);
    cycle(pcode(2), 1'b1, pcode(2), 1'b1, 2'b00, 16'h4321, "R9");
    cycle(pcode(5), 1'b1, pcode(5), 1'b0, 2'b11, 16'h0000, "R9");
    cycle(5'b00101, 1'b1, 5'b11110, 1'b0, 2'b00, 16'h0000, "R9");
    readback("R9");

    // R1: reset in mid-run clears loaded state.
    do_reset();
    readback("R1");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule